// File: doc/BRIEF.md
# DMA Request Register Front-End

This block is the software-facing side of a single-channel DMA engine. A processor writes a descriptor into staging registers over a plain 32-bit register bus: the two addresses, the two strides, the row length, the row count and a cyclic flag. It then commits the descriptor with a write to a launch register. The block holds the committed descriptor in a one-entry request slot and offers it to the transfer engine through a valid/ready port. Each committed descriptor is tagged with a 5-bit identifier that the block hands out in rising order and that wraps modulo 32.

The engine reports each finished transfer by pulsing its identifier back. The block keeps one completion bit per identifier, and it raises two interrupt causes. The first cause is set when the engine accepts a request, which means the slot has room again. The second is set when a transfer finishes. A mask decides which pending causes drive the interrupt line. Software probes which features were built in by writing to the flag and length registers and reading them back: bits that were not built in read as zero.

Top module: `dmareq_frontend`

## Requirements
- R1: After reset the interrupt mask reads 0x3 (both causes masked), pending reads 0, control reads 0, the next-ID register reads 0, the completion map reads 0, and neither req_valid nor irq is asserted.
- R2: With enable set (control bit 0) and the slot empty, writing bit 0 of the launch register (0x408) places the staged descriptor on the req_* outputs, tagged with the value the next-ID register (0x404) showed. The next-ID register then advances by one, wrapping from 31 to 0.
- R3: The launch register reads 1 while a request waits in the slot and 0 otherwise. A launch while the slot is occupied is ignored: the ID and the offered fields do not change.
- R4: Writing control with bit 0 clear drops any waiting request. A launch written while enable is clear is ignored and does not advance the next-ID register.
- R5: While the pause bit (control bit 1) is set, req_valid stays low but the waiting request is kept. Clearing pause presents the request again with the same ID.
- R6: When the engine takes a request (req_valid and req_ready high at a clock edge), the slot empties, pending bit 0 is set, and the active-ID register (0x42C) shows that ID. It keeps that value while the engine is idle.
- R7: A done_valid pulse sets the completion-map bit (0x428) that done_id selects, and it sets pending bit 1.
- R8: Allocating an ID to a new request clears that ID's completion-map bit.
- R9: Writing the pending register (0x84) clears the bits written as 1. When an event sets a bit in the same cycle as such a write, the bit stays set.
- R10: irq is high exactly when some pending bit has its mask bit (0x80) clear. The cause register (0x88) reads pending AND NOT mask.
- R11: Flag bit 0 (0x40C) reads back what was written when cyclic support is built in, and 0 otherwise. The stored value drives req_cyclic.
- R12: The row-length register (0x418) reads back only its XLEN_W low bits, so writing all ones returns 2^XLEN_W-1. The row-count register (0x41C) reads back YLEN_W bits when two-dimensional support is built in, and 0 otherwise.
- R13: Any offset not listed above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ctrl_enable | output | 1 | Channel enable to the engine |
| ctrl_pause | output | 1 | Pause to the engine |
| req_valid | output | 1 | Request offered to the engine |
| req_ready | input | 1 | Engine takes the request |
| req_id | output | ID_W | Identifier of the offered request |
| req_dst_addr | output | ADDR_W | Destination start address |
| req_src_addr | output | ADDR_W | Source start address |
| req_dst_stride | output | ADDR_W | Destination row stride |
| req_src_stride | output | ADDR_W | Source row stride |
| req_xlen | output | XLEN_W | Row length minus one |
| req_ylen | output | YLEN_W | Row count minus one |
| req_cyclic | output | 1 | Repeat the transfer |
| done_valid | input | 1 | Engine finished a transfer |
| done_id | input | ID_W | Identifier of the finished transfer |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach from the ports is reuse of an identifier whose completion bit is still set. That state exists only after the allocator has handed out all 32 identifiers. The stimulus first marks two IDs as completed. It then runs launch/accept pairs until the next-ID register wraps to 0, and checks that the next launch clears bit 0 while bit 1 stays set. A second hard case is a completion pulse in the same cycle as a write that clears pending. The bench drives both at one falling edge so that they land on the same rising edge.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
    // register byte offsets (software-visible map)
    localparam logic [11:0] OFS_IRQ_MASK  = 12'h080;
    localparam logic [11:0] OFS_IRQ_PEND  = 12'h084;
    localparam logic [11:0] OFS_IRQ_CAUSE = 12'h088;
    localparam logic [11:0] OFS_CTRL      = 12'h400;
    localparam logic [11:0] OFS_NEXT_ID   = 12'h404;
    localparam logic [11:0] OFS_LAUNCH    = 12'h408;
    localparam logic [11:0] OFS_FLAGS     = 12'h40C;
    localparam logic [11:0] OFS_DST       = 12'h410;
    localparam logic [11:0] OFS_SRC       = 12'h414;
    localparam logic [11:0] OFS_XLEN      = 12'h418;
    localparam logic [11:0] OFS_YLEN      = 12'h41C;
    localparam logic [11:0] OFS_DST_STR   = 12'h420;
    localparam logic [11:0] OFS_SRC_STR   = 12'h424;
    localparam logic [11:0] OFS_DONE_MAP  = 12'h428;
    localparam logic [11:0] OFS_ACTIVE_ID = 12'h42C;

    // interrupt cause bit positions
    localparam int IRQ_N   = 2;
    localparam int IRQ_SOT = 0;
    localparam int IRQ_EOT = 1;
endpackage

// File: rtl/dmareq_cfg_regs.sv
module dmareq_cfg_regs #(
    parameter int ADDR_W     = 32,
    parameter int XLEN_W     = 24,
    parameter int YLEN_W     = 16,
    parameter bit HAS_CYCLIC = 1'b1,
    parameter bit HAS_2D     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic              en,
    output logic              pause,
    output logic              cyclic,
    output logic [ADDR_W-1:0] dst,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst_str,
    output logic [ADDR_W-1:0] src_str,
    output logic [XLEN_W-1:0] xlen,
    output logic [YLEN_W-1:0] ylen
);
    import dmareq_pkg::*;

    typedef struct packed {
        logic              en;
        logic              pause;
        logic              cyc;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst_str;
        logic [ADDR_W-1:0] src_str;
        logic [XLEN_W-1:0] xlen;
        logic [YLEN_W-1:0] ylen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic              cyc_keep;
    logic [YLEN_W-1:0] ylen_keep;

    // feature variants: unbuilt bits are tied so they read back as zero
    generate
        if (HAS_CYCLIC) begin : g_cyc
            assign cyc_keep = 1'b1;
        end else begin : g_nocyc
            assign cyc_keep = 1'b0;
        end
        if (HAS_2D) begin : g_2d
            assign ylen_keep = '1;
        end else begin : g_no2d
            assign ylen_keep = '0;
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (addr)
                OFS_CTRL: begin
                    cfg_d.en    = wdata[0];
                    cfg_d.pause = wdata[1];
                end
                OFS_FLAGS:   cfg_d.cyc     = wdata[0] & cyc_keep;
                OFS_DST:     cfg_d.dst     = wdata[ADDR_W-1:0];
                OFS_SRC:     cfg_d.src     = wdata[ADDR_W-1:0];
                OFS_DST_STR: cfg_d.dst_str = wdata[ADDR_W-1:0];
                OFS_SRC_STR: cfg_d.src_str = wdata[ADDR_W-1:0];
                OFS_XLEN:    cfg_d.xlen    = wdata[XLEN_W-1:0];
                OFS_YLEN:    cfg_d.ylen    = wdata[YLEN_W-1:0] & ylen_keep;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en      = cfg_q.en;
    assign pause   = cfg_q.pause;
    assign cyclic  = cfg_q.cyc;
    assign dst     = cfg_q.dst;
    assign src     = cfg_q.src;
    assign dst_str = cfg_q.dst_str;
    assign src_str = cfg_q.src_str;
    assign xlen    = cfg_q.xlen;
    assign ylen    = cfg_q.ylen;
endmodule

// File: rtl/dmareq_id_slot.sv
module dmareq_id_slot #(
    parameter int ADDR_W = 32,
    parameter int XLEN_W = 24,
    parameter int YLEN_W = 16,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              flush,
    input  logic              en,
    input  logic              pause,
    input  logic              stg_cyc,
    input  logic [ADDR_W-1:0] stg_dst,
    input  logic [ADDR_W-1:0] stg_src,
    input  logic [ADDR_W-1:0] stg_dst_str,
    input  logic [ADDR_W-1:0] stg_src_str,
    input  logic [XLEN_W-1:0] stg_xlen,
    input  logic [YLEN_W-1:0] stg_ylen,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ID_W-1:0]   req_id,
    output logic [ADDR_W-1:0] req_dst,
    output logic [ADDR_W-1:0] req_src,
    output logic [ADDR_W-1:0] req_dst_str,
    output logic [ADDR_W-1:0] req_src_str,
    output logic [XLEN_W-1:0] req_xlen,
    output logic [YLEN_W-1:0] req_ylen,
    output logic              req_cyc,
    output logic              slot_full,
    output logic              accept,
    output logic              alloc,
    output logic [ID_W-1:0]   next_id,
    output logic [ID_W-1:0]   active_id
);
    typedef struct packed {
        logic              full;
        logic [ID_W-1:0]   id;
        logic [ID_W-1:0]   next_id;
        logic [ID_W-1:0]   active;
        logic              cyc;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst_str;
        logic [ADDR_W-1:0] src_str;
        logic [XLEN_W-1:0] xlen;
        logic [YLEN_W-1:0] ylen;
    } slot_t;

    slot_t slot_d, slot_q;

    assign req_valid = slot_q.full && en && !pause;

    always_comb begin
        slot_d = slot_q;
        accept = req_valid && req_ready;
        alloc  = launch && en && !slot_q.full;
        if (accept) begin
            slot_d.full   = 1'b0;
            slot_d.active = slot_q.id;
        end
        if (flush) slot_d.full = 1'b0;
        if (alloc) begin
            slot_d.full    = 1'b1;
            slot_d.id      = slot_q.next_id;
            slot_d.next_id = slot_q.next_id + 1'b1;
            slot_d.cyc     = stg_cyc;
            slot_d.dst     = stg_dst;
            slot_d.src     = stg_src;
            slot_d.dst_str = stg_dst_str;
            slot_d.src_str = stg_src_str;
            slot_d.xlen    = stg_xlen;
            slot_d.ylen    = stg_ylen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign req_id      = slot_q.id;
    assign req_dst     = slot_q.dst;
    assign req_src     = slot_q.src;
    assign req_dst_str = slot_q.dst_str;
    assign req_src_str = slot_q.src_str;
    assign req_xlen    = slot_q.xlen;
    assign req_ylen    = slot_q.ylen;
    assign req_cyc     = slot_q.cyc;
    assign slot_full   = slot_q.full;
    assign next_id     = slot_q.next_id;
    assign active_id   = slot_q.active;
endmodule

// File: rtl/dmareq_irq_done.sv
module dmareq_irq_done #(
    parameter int ID_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mask_wr,
    input  logic                         pend_wr,
    input  logic [dmareq_pkg::IRQ_N-1:0] wbits,
    input  logic                         sot_evt,
    input  logic                         done_valid,
    input  logic [ID_W-1:0]              done_id,
    input  logic                         alloc,
    input  logic [ID_W-1:0]              alloc_id,
    output logic [dmareq_pkg::IRQ_N-1:0] mask,
    output logic [dmareq_pkg::IRQ_N-1:0] pend,
    output logic [(1<<ID_W)-1:0]         done_map,
    output logic                         irq
);
    import dmareq_pkg::*;
    localparam int NUM_IDS = 1 << ID_W;

    typedef struct packed {
        logic [IRQ_N-1:0]   mask;
        logic [IRQ_N-1:0]   pend;
        logic [NUM_IDS-1:0] done;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [NUM_IDS-1:0] done_nxt;

    // per-ID completion bit: reallocation clears, completion sets (set wins)
    generate
        for (genvar i = 0; i < NUM_IDS; i++) begin : g_done
            assign done_nxt[i] = (irq_q.done[i] && !(alloc && alloc_id == ID_W'(i)))
                               || (done_valid && done_id == ID_W'(i));
        end
    endgenerate

    always_comb begin
        irq_d      = irq_q;
        irq_d.done = done_nxt;
        if (mask_wr) irq_d.mask = wbits;
        if (pend_wr) irq_d.pend = irq_q.pend & ~wbits;
        if (sot_evt)    irq_d.pend[IRQ_SOT] = 1'b1;
        if (done_valid) irq_d.pend[IRQ_EOT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q      <= '0;
            irq_q.mask <= '1;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign mask     = irq_q.mask;
    assign pend     = irq_q.pend;
    assign done_map = irq_q.done;
    assign irq      = |(irq_q.pend & ~irq_q.mask);
endmodule

// File: rtl/dmareq_frontend.sv
module dmareq_frontend #(
    parameter int ADDR_W     = 32,
    parameter int XLEN_W     = 24,
    parameter int YLEN_W     = 16,
    parameter int ID_W       = 5,
    parameter bit HAS_CYCLIC = 1'b1,
    parameter bit HAS_2D     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctrl_enable,
    output logic              ctrl_pause,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ID_W-1:0]   req_id,
    output logic [ADDR_W-1:0] req_dst_addr,
    output logic [ADDR_W-1:0] req_src_addr,
    output logic [ADDR_W-1:0] req_dst_stride,
    output logic [ADDR_W-1:0] req_src_stride,
    output logic [XLEN_W-1:0] req_xlen,
    output logic [YLEN_W-1:0] req_ylen,
    output logic              req_cyclic,
    input  logic              done_valid,
    input  logic [ID_W-1:0]   done_id,
    output logic              irq
);
    import dmareq_pkg::*;
    localparam int NUM_IDS = 1 << ID_W;

    logic              stg_cyc;
    logic [ADDR_W-1:0] stg_dst, stg_src, stg_dst_str, stg_src_str;
    logic [XLEN_W-1:0] stg_xlen;
    logic [YLEN_W-1:0] stg_ylen;
    logic              launch, flush, slot_full, accept, alloc;
    logic [ID_W-1:0]   next_id, active_id;
    logic [IRQ_N-1:0]  irq_mask, irq_pend;
    logic [NUM_IDS-1:0] done_map;

    assign launch = bus_wr && bus_addr == OFS_LAUNCH && bus_wdata[0];
    assign flush  = bus_wr && bus_addr == OFS_CTRL && !bus_wdata[0];

    dmareq_cfg_regs #(
        .ADDR_W(ADDR_W), .XLEN_W(XLEN_W), .YLEN_W(YLEN_W),
        .HAS_CYCLIC(HAS_CYCLIC), .HAS_2D(HAS_2D)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .en(ctrl_enable), .pause(ctrl_pause), .cyclic(stg_cyc),
        .dst(stg_dst), .src(stg_src), .dst_str(stg_dst_str), .src_str(stg_src_str),
        .xlen(stg_xlen), .ylen(stg_ylen)
    );

    dmareq_id_slot #(
        .ADDR_W(ADDR_W), .XLEN_W(XLEN_W), .YLEN_W(YLEN_W), .ID_W(ID_W)
    ) slot_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .flush(flush),
        .en(ctrl_enable), .pause(ctrl_pause), .stg_cyc(stg_cyc),
        .stg_dst(stg_dst), .stg_src(stg_src), .stg_dst_str(stg_dst_str),
        .stg_src_str(stg_src_str), .stg_xlen(stg_xlen), .stg_ylen(stg_ylen),
        .req_ready(req_ready), .req_valid(req_valid), .req_id(req_id),
        .req_dst(req_dst_addr), .req_src(req_src_addr),
        .req_dst_str(req_dst_stride), .req_src_str(req_src_stride),
        .req_xlen(req_xlen), .req_ylen(req_ylen), .req_cyc(req_cyclic),
        .slot_full(slot_full), .accept(accept), .alloc(alloc),
        .next_id(next_id), .active_id(active_id)
    );

    dmareq_irq_done #(.ID_W(ID_W)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .mask_wr(bus_wr && bus_addr == OFS_IRQ_MASK),
        .pend_wr(bus_wr && bus_addr == OFS_IRQ_PEND),
        .wbits(bus_wdata[IRQ_N-1:0]), .sot_evt(accept),
        .done_valid(done_valid), .done_id(done_id),
        .alloc(alloc), .alloc_id(next_id),
        .mask(irq_mask), .pend(irq_pend), .done_map(done_map), .irq(irq)
    );

    // combinational read port
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IRQ_MASK:  bus_rdata[IRQ_N-1:0]   = irq_mask;
            OFS_IRQ_PEND:  bus_rdata[IRQ_N-1:0]   = irq_pend;
            OFS_IRQ_CAUSE: bus_rdata[IRQ_N-1:0]   = irq_pend & ~irq_mask;
            OFS_CTRL:      bus_rdata[1:0]         = {ctrl_pause, ctrl_enable};
            OFS_NEXT_ID:   bus_rdata[ID_W-1:0]    = next_id;
            OFS_LAUNCH:    bus_rdata[0]           = slot_full;
            OFS_FLAGS:     bus_rdata[0]           = stg_cyc;
            OFS_DST:       bus_rdata[ADDR_W-1:0]  = stg_dst;
            OFS_SRC:       bus_rdata[ADDR_W-1:0]  = stg_src;
            OFS_XLEN:      bus_rdata[XLEN_W-1:0]  = stg_xlen;
            OFS_YLEN:      bus_rdata[YLEN_W-1:0]  = stg_ylen;
            OFS_DST_STR:   bus_rdata[ADDR_W-1:0]  = stg_dst_str;
            OFS_SRC_STR:   bus_rdata[ADDR_W-1:0]  = stg_src_str;
            OFS_DONE_MAP:  bus_rdata[NUM_IDS-1:0] = done_map;
            OFS_ACTIVE_ID: bus_rdata[ID_W-1:0]    = active_id;
            default: ;
        endcase
    end
endmodule

// File: rtl/dmareq_frontend_chk.sv
module dmareq_frontend_chk #(
    parameter int ID_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ID_W-1:0]      req_id,
    input logic                 ctrl_enable,
    input logic                 ctrl_pause,
    input logic                 done_valid,
    input logic [ID_W-1:0]      done_id,
    input logic                 irq,
    input logic [ID_W-1:0]      next_id,
    input logic [1:0]           irq_pend,
    input logic [(1<<ID_W)-1:0] done_map
);
    // R2: the allocator only ever steps by one
    assert_id_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_id) |-> next_id == $past(next_id) + 1'b1);

    // R3: an offered request stays put until taken (bus idle)
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !bus_wr) |=> (req_valid && $stable(req_id)));

    // R4: nothing is offered while the channel is disabled
    assert_no_req_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_enable |-> !req_valid);

    // R5: pause withholds the request
    assert_pause_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_pause |-> !req_valid);

    // R6: acceptance raises the start-of-transfer cause
    assert_sot_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> irq_pend[0]);

    // R7: completion marks the map and raises end-of-transfer
    assert_eot_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (irq_pend[1] && done_map[$past(done_id)]));

    // R10: the line can only rise after an event or a register write
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_wr || done_valid || (req_valid && req_ready)));
endmodule

bind dmareq_frontend dmareq_frontend_chk #(.ID_W(ID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .ctrl_enable(ctrl_enable),
    .ctrl_pause(ctrl_pause), .done_valid(done_valid), .done_id(done_id),
    .irq(irq), .next_id(next_id), .irq_pend(irq_pend), .done_map(done_map)
);

// File: tb/dmareq_frontend_tb_top.sv
module dmareq_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ctrl_enable, ctrl_pause, req_valid, req_cyclic, irq;
    logic        req_ready = 1'b0;
    logic        done_valid = 1'b0;
    logic [4:0]  done_id = '0;
    logic [4:0]  req_id;
    logic [31:0] req_dst_addr, req_src_addr, req_dst_stride, req_src_stride;
    logic [23:0] req_xlen;
    logic [15:0] req_ylen;

    int total = 0;
    int bad = 0;
    int exp_id = 0;

    always #10 clk = ~clk;

    dmareq_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_enable(ctrl_enable), .ctrl_pause(ctrl_pause),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .req_xlen(req_xlen), .req_ylen(req_ylen), .req_cyclic(req_cyclic),
        .done_valid(done_valid), .done_id(done_id), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic take();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        #1;
    endtask

    task automatic finish_id(input logic [4:0] id);
        @(negedge clk); done_valid = 1'b1; done_id = id;
        @(negedge clk); done_valid = 1'b0;
        #1;
    endtask

    task automatic launch();
        wr(12'h408, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h080, v); chk("R1 mask", v, 32'h3);
        rd(12'h084, v); chk("R1 pending", v, 32'h0);
        rd(12'h400, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h404, v); chk("R1 next id", v, 32'h0);
        rd(12'h428, v); chk("R1 done map", v, 32'h0);
        chk("R1 req_valid/irq", {req_valid, irq}, 32'h0);
    endtask

    task automatic t_submit();
        logic [31:0] v;
        wr(12'h400, 32'h1);
        wr(12'h410, 32'h0000_1000); wr(12'h414, 32'h0000_2000);
        wr(12'h418, 32'hFF);        wr(12'h41C, 32'h3);
        wr(12'h420, 32'h40);        wr(12'h424, 32'h80);
        wr(12'h40C, 32'h1);
        launch(); exp_id = 1;
        chk("R2 req_valid", req_valid, 1);
        chk("R2 req_id", req_id, 0);
        chk("R2 dst/src", {req_dst_addr[15:0], req_src_addr[15:0]}, 32'h1000_2000);
        chk("R2 strides", {req_dst_stride[15:0], req_src_stride[15:0]}, 32'h0040_0080);
        chk("R2 lengths", {req_xlen[15:0], req_ylen}, 32'h00FF_0003);
        chk("R11 req_cyclic", req_cyclic, 1);
        rd(12'h404, v); chk("R2 next id", v, 1);
        rd(12'h408, v); chk("R3 launch reads busy", v, 1);
    endtask

    task automatic t_full();
        logic [31:0] v;
        wr(12'h410, 32'h5555_5555);
        launch();
        rd(12'h404, v); chk("R3 id unchanged when full", v, 1);
        chk("R3 fields unchanged", req_dst_addr, 32'h0000_1000);
        chk("R3 req_id unchanged", req_id, 0);
    endtask

    task automatic t_accept();
        logic [31:0] v;
        take();
        chk("R6 slot empties", req_valid, 0);
        rd(12'h408, v); chk("R3 launch reads idle", v, 0);
        rd(12'h084, v); chk("R6 sot pending", v, 32'h1);
        rd(12'h42C, v); chk("R6 active id", v, 0);
        chk("R10 masked irq low", irq, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(12'h080, 32'h0);
        chk("R10 irq unmasked", irq, 1);
        rd(12'h088, v); chk("R10 cause", v, 32'h1);
        wr(12'h084, 32'h1);
        rd(12'h084, v); chk("R9 w1c", v, 0);
        chk("R10 irq after clear", irq, 0);
    endtask

    task automatic t_done();
        logic [31:0] v;
        finish_id(5'd0);
        rd(12'h428, v); chk("R7 done bit0", v, 32'h1);
        rd(12'h084, v); chk("R7 eot pending", v, 32'h2);
        chk("R7 irq", irq, 1);
        wr(12'h084, 32'h3);
        launch(); chk("R2 second id", req_id, 1); exp_id = 2;
        take(); finish_id(5'd1);
        rd(12'h428, v); chk("R7 done map", v, 32'h3);
    endtask

    task automatic t_w1c_race();
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 12'h084; bus_wdata = 32'h3; bus_wr = 1'b1;
        done_valid = 1'b1; done_id = 5'd5;
        @(negedge clk);
        bus_wr = 1'b0; done_valid = 1'b0;
        rd(12'h084, v); chk("R9 set wins over clear", v, 32'h2);
        wr(12'h084, 32'h2);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        launch(); exp_id = 3;
        chk("R4 pre req_valid", req_valid, 1);
        wr(12'h400, 32'h0);
        chk("R4 dropped", req_valid, 0);
        rd(12'h408, v); chk("R4 slot empty", v, 0);
        launch();
        rd(12'h404, v); chk("R4 launch ignored", v, 3);
        wr(12'h400, 32'h1);
        chk("R4 still dropped", req_valid, 0);
    endtask

    task automatic t_pause();
        logic [31:0] v;
        wr(12'h400, 32'h3);
        launch(); exp_id = 4;
        chk("R5 withheld", req_valid, 0);
        rd(12'h408, v); chk("R5 kept", v, 1);
        wr(12'h400, 32'h1);
        chk("R5 released", req_valid, 1);
        chk("R5 same id", req_id, 3);
        take();
        repeat (4) @(negedge clk);
        rd(12'h42C, v); chk("R6 active holds", v, 3);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        while (exp_id != 32) begin
            launch(); take(); exp_id++;
        end
        rd(12'h404, v); chk("R2 wrap to 0", v, 0);
        launch();
        chk("R2 reused id", req_id, 0);
        rd(12'h428, v); chk("R8 realloc clears", v, 32'h2);
        take();
        rd(12'h42C, v); chk("R6 active after wrap", v, 0);
    endtask

    task automatic t_probe();
        logic [31:0] v;
        wr(12'h418, 32'hFFFF_FFFF);
        rd(12'h418, v); chk("R12 xlen width", v, 32'h00FF_FFFF);
        wr(12'h41C, 32'hFFFF_FFFF);
        rd(12'h41C, v); chk("R12 ylen width", v, 32'h0000_FFFF);
        wr(12'h40C, 32'hFFFF_FFFF);
        rd(12'h40C, v); chk("R11 flags", v, 32'h1);
        rd(12'h100, v); chk("R13 unmapped", v, 0);
        rd(12'h430, v); chk("R13 unmapped high", v, 0);
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_submit();
        t_full();
        t_accept();
        t_mask();
        t_done();
        t_w1c_race();
        t_disable();
        t_pause();
        t_wrap();
        t_probe();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule